// File: doc/BRIEF.md
# Command Ring Descriptor and Slot Address Translator

This block keeps the descriptor of one command ring that lives in memory: the ring's base address, the number of slots it holds, a producer (write) index and a consumer (read) index. Both indices only ever count upward. The block never wraps them. Wrapping happens only when an index is turned into a memory address. Every slot carries one fixed 64-byte command packet.

A controller loads a new ring with a single configure strobe. The strobe carries the base address, the ring size in bytes and a mode bit. From then on the controller moves the two indices through their update ports. It can hand any index to the translation port and get back the byte address of the slot that index lands on, in the same cycle. The block also reports how many slots are occupied, how many are free, and whether the ring is full or empty.

The mode bit selects a compatibility layout. In that layout the ring reserves twice the memory it actually touches, so slot indices wrap at half the slot count. The block does no memory access of its own.

Top module: `rq_ring_desc`

## Requirements
- R1: A slot is 64 bytes. The slot count is the configured byte size divided by 64. The byte size must be a power of two and at least 64, so the slot count is also a power of two.
- R2: With the mode bit at 0, the slot address is base + (index mod slot count) * 64.
- R3: With the mode bit at 1, the slot address is base + (index mod (slot count / 2)) * 64. A ring with a single slot maps every index to the base.
- R4: Space used is the write index minus the read index, taken modulo 2^IDX_W. This stays correct after either index passes its top value.
- R5: Space remaining is the slot count minus space used.
- R6: Full is 1 exactly when space remaining is 0. Empty is 1 exactly when space remaining equals the slot count.
- R7: A configure strobe loads base, slot count and mode. It also sets both indices to zero. All of this takes effect on the next clock edge.
- R8: An index update port loads its own index on the next edge and leaves the other index unchanged. A configure strobe in the same cycle takes priority over both update ports.
- R9: The slot address follows the translate input combinationally, in the same cycle, with no clock edge needed.
- R10: After reset, base, slot count and both indices are zero. The outputs are then address 0, used 0, remaining 0, with full and empty both at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_valid_i | input | 1 | Configure strobe |
| cfg_base_i | input | ADDR_W | Ring base address |
| cfg_size_i | input | SIZE_W | Ring size in bytes, a power of two |
| cfg_half_i | input | 1 | 1 selects the half-wrap compatibility layout |
| wr_idx_we_i | input | 1 | Write-index load enable |
| wr_idx_i | input | IDX_W | New write index |
| rd_idx_we_i | input | 1 | Read-index load enable |
| rd_idx_i | input | IDX_W | New read index |
| slot_idx_i | input | IDX_W | Index to translate |
| slot_addr_o | output | ADDR_W | Byte address of the slot |
| space_used_o | output | IDX_W | Occupied slots |
| space_left_o | output | IDX_W | Free slots |
| full_o | output | 1 | No free slot |
| empty_o | output | 1 | No occupied slot |

## Verification
The bench builds the block with IDX_W=16, ADDR_W=32 and SIZE_W=24. The narrow 16-bit index lets a short run put the read index just below its top value while the write index has already wrapped past zero, so the modular subtraction in space used is tested directly. It also lets translate indices near the top of the index range be applied. Ring sizes from a single slot up to 64 slots cover both wrap layouts, including the single-slot case where the half-wrap mask collapses to zero.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // Fixed packet slot geometry
  localparam int unsigned SLOT_BYTES = 64;
  localparam int unsigned SLOT_LOG2  = $clog2(SLOT_BYTES);

  // Wrap layout selected by the configure mode bit
  typedef enum logic {
    RQ_WRAP_FULL = 1'b0,
    RQ_WRAP_HALF = 1'b1
  } rq_wrap_e;
endpackage

// File: rtl/rq_rst_sync.sv
module rq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/rq_desc_regs.sv
module rq_desc_regs
  import rq_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned IDX_W  = 64,
  parameter int unsigned SIZE_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [SIZE_W-1:0] cfg_size_i,
  input  logic              cfg_half_i,
  input  logic              wr_idx_we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              rd_idx_we_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  elts_o,
  output logic [IDX_W-1:0]  mask_o,
  output rq_wrap_e          wrap_o,
  output logic [IDX_W-1:0]  wr_o,
  output logic [IDX_W-1:0]  rd_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]  elts_q, elts_d;
  logic [IDX_W-1:0]  mask_q, mask_d;
  rq_wrap_e          wrap_q, wrap_d;
  logic [IDX_W-1:0]  wr_q, wr_d;
  logic [IDX_W-1:0]  rd_q, rd_d;
  logic              desc_en, wr_en, rd_en;
  logic [IDX_W-1:0]  new_elts;

  assign new_elts = IDX_W'(cfg_size_i >> SLOT_LOG2);

  // Next-state: configure overrides both index ports
  always_comb begin
    desc_en = cfg_valid_i;
    wr_en   = cfg_valid_i | wr_idx_we_i;
    rd_en   = cfg_valid_i | rd_idx_we_i;
    base_d  = cfg_base_i;
    elts_d  = new_elts;
    mask_d  = new_elts - IDX_W'(1);
    wrap_d  = cfg_half_i ? RQ_WRAP_HALF : RQ_WRAP_FULL;
    wr_d    = cfg_valid_i ? '0 : wr_idx_i;
    rd_d    = cfg_valid_i ? '0 : rd_idx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      elts_q <= '0;
      mask_q <= '0;
      wrap_q <= RQ_WRAP_FULL;
    end else if (desc_en) begin
      base_q <= base_d;
      elts_q <= elts_d;
      mask_q <= mask_d;
      wrap_q <= wrap_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
    end else if (wr_en) begin
      wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign base_o = base_q;
  assign elts_o = elts_q;
  assign mask_o = mask_q;
  assign wrap_o = wrap_q;
  assign wr_o   = wr_q;
  assign rd_o   = rd_q;
endmodule

// File: rtl/rq_slot_xlate.sv
module rq_slot_xlate
  import rq_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned IDX_W  = 64
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  mask_i,
  input  rq_wrap_e          wrap_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [IDX_W-1:0]  sel_mask;
  logic [IDX_W-1:0]  slot;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    // Half-wrap layout: mask of half the count, which is 0 for one slot
    sel_mask = (wrap_i == RQ_WRAP_HALF) ? (mask_i >> 1) : mask_i;
    slot     = idx_i & sel_mask;
    offset   = ADDR_W'(slot) << SLOT_LOG2;
    addr_o   = base_i + offset;
  end
endmodule

// File: rtl/rq_occupancy.sv
module rq_occupancy #(
  parameter int unsigned IDX_W = 64
) (
  input  logic [IDX_W-1:0] wr_i,
  input  logic [IDX_W-1:0] rd_i,
  input  logic [IDX_W-1:0] elts_i,
  output logic [IDX_W-1:0] used_o,
  output logic [IDX_W-1:0] left_o,
  output logic             full_o,
  output logic             empty_o
);
  always_comb begin
    used_o  = wr_i - rd_i;
    left_o  = elts_i - used_o;
    full_o  = (left_o == '0);
    empty_o = (left_o == elts_i);
  end
endmodule

// File: rtl/rq_ring_desc.sv
module rq_ring_desc
  import rq_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned IDX_W  = 64,
  parameter int unsigned SIZE_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [SIZE_W-1:0] cfg_size_i,
  input  logic              cfg_half_i,
  input  logic              wr_idx_we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              rd_idx_we_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  slot_idx_i,
  output logic [ADDR_W-1:0] slot_addr_o,
  output logic [IDX_W-1:0]  space_used_o,
  output logic [IDX_W-1:0]  space_left_o,
  output logic              full_o,
  output logic              empty_o
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  elts_q;
  logic [IDX_W-1:0]  mask_q;
  rq_wrap_e          wrap_q;
  logic [IDX_W-1:0]  wr_q;
  logic [IDX_W-1:0]  rd_q;

  rq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  rq_desc_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .cfg_valid_i (cfg_valid_i),
    .cfg_base_i  (cfg_base_i),
    .cfg_size_i  (cfg_size_i),
    .cfg_half_i  (cfg_half_i),
    .wr_idx_we_i (wr_idx_we_i),
    .wr_idx_i    (wr_idx_i),
    .rd_idx_we_i (rd_idx_we_i),
    .rd_idx_i    (rd_idx_i),
    .base_o      (base_q),
    .elts_o      (elts_q),
    .mask_o      (mask_q),
    .wrap_o      (wrap_q),
    .wr_o        (wr_q),
    .rd_o        (rd_q)
  );

  rq_slot_xlate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_xlate (
    .base_i (base_q),
    .mask_i (mask_q),
    .wrap_i (wrap_q),
    .idx_i  (slot_idx_i),
    .addr_o (slot_addr_o)
  );

  rq_occupancy #(.IDX_W(IDX_W)) u_occ (
    .wr_i    (wr_q),
    .rd_i    (rd_q),
    .elts_i  (elts_q),
    .used_o  (space_used_o),
    .left_o  (space_left_o),
    .full_o  (full_o),
    .empty_o (empty_o)
  );
endmodule

// File: rtl/rq_ring_desc_chk.sv
module rq_ring_desc_chk #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned IDX_W  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_valid_i,
  input logic              wr_idx_we_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [ADDR_W-1:0] slot_addr_o,
  input logic [IDX_W-1:0]  space_used_o,
  input logic [IDX_W-1:0]  space_left_o,
  input logic              full_o,
  input logic              empty_o,
  input logic [ADDR_W-1:0] base_q,
  input logic [IDX_W-1:0]  elts_q,
  input logic              half_q,
  input logic [IDX_W-1:0]  wr_q,
  input logic [IDX_W-1:0]  rd_q
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] span;
  assign off  = slot_addr_o - base_q;
  assign span = ADDR_W'(elts_q) << 6;

  p_cfg_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i |=> (wr_q == '0 && rd_q == '0));

  p_wr_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_valid_i && wr_idx_we_i) |=> (wr_q == $past(wr_idx_i)));

  p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_valid_i && !wr_idx_we_i) |=> $stable(wr_q));

  p_space_sum_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    IDX_W'(space_used_o + space_left_o) == elts_q);

  p_full_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elts_q != '0) |-> !(full_o && empty_o));

  p_slot_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_addr_o[5:0] == base_q[5:0]);

  p_slot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_q && elts_q != '0) |-> (off < span));

  p_half_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_q && elts_q > IDX_W'(1)) |-> (off < (span >> 1)));
endmodule

bind rq_ring_desc rq_ring_desc_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_valid_i  (cfg_valid_i),
  .wr_idx_we_i  (wr_idx_we_i),
  .wr_idx_i     (wr_idx_i),
  .slot_addr_o  (slot_addr_o),
  .space_used_o (space_used_o),
  .space_left_o (space_left_o),
  .full_o       (full_o),
  .empty_o      (empty_o),
  .base_q       (base_q),
  .elts_q       (elts_q),
  .half_q       (wrap_q == rq_pkg::RQ_WRAP_HALF),
  .wr_q         (wr_q),
  .rd_q         (rd_q)
);

// File: tb/tb_rq_ring_desc.sv
module tb_rq_ring_desc;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IDX_W  = 16;
  localparam int unsigned SIZE_W = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_valid;
  logic [ADDR_W-1:0] cfg_base;
  logic [SIZE_W-1:0] cfg_size;
  logic              cfg_half;
  logic              wr_we;
  logic [IDX_W-1:0]  wr_val;
  logic              rd_we;
  logic [IDX_W-1:0]  rd_val;
  logic [IDX_W-1:0]  slot_idx;
  logic [ADDR_W-1:0] slot_addr;
  logic [IDX_W-1:0]  used, left;
  logic              full, empty;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rq_ring_desc #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_base_i(cfg_base),
    .cfg_size_i(cfg_size), .cfg_half_i(cfg_half), .wr_idx_we_i(wr_we),
    .wr_idx_i(wr_val), .rd_idx_we_i(rd_we), .rd_idx_i(rd_val),
    .slot_idx_i(slot_idx), .slot_addr_o(slot_addr), .space_used_o(used),
    .space_left_o(left), .full_o(full), .empty_o(empty)
  );

  typedef struct packed {
    logic              half;
    logic [SIZE_W-1:0] size;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  wr;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] e_addr;
    logic [IDX_W-1:0]  e_used;
    logic [IDX_W-1:0]  e_left;
    logic              e_full;
    logic              e_empty;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    // R2: 16 slots, 21 mod 16 = 5
    '{1'b0, 24'd1024, 32'h1000, 16'd5,      16'd2,      16'd21,     32'h1140, 16'd3, 16'd13, 1'b0, 1'b0},
    // R3: half layout, 21 mod 8 = 5; ring full
    '{1'b1, 24'd1024, 32'h1000, 16'd16,     16'd0,      16'd21,     32'h1140, 16'd16, 16'd0, 1'b1, 1'b0},
    // R3: 12 mod 8 = 4; empty
    '{1'b1, 24'd1024, 32'h2000, 16'd7,      16'd7,      16'd12,     32'h2100, 16'd0, 16'd16, 1'b0, 1'b1},
    // R4: write index wrapped past zero, 64 slots
    '{1'b0, 24'd4096, 32'h8000, 16'h0003,   16'hFFFD,   16'hFFFF,   32'h8FC0, 16'd6, 16'd58, 1'b0, 1'b0},
    // R1: single slot, full
    '{1'b0, 24'd64,   32'h0040, 16'd1,      16'd0,      16'h1234,   32'h0040, 16'd1, 16'd0,  1'b1, 1'b0},
    // R3: single slot in half layout maps to base
    '{1'b1, 24'd64,   32'h0040, 16'd0,      16'd0,      16'd7,      32'h0040, 16'd0, 16'd1,  1'b0, 1'b1},
    // R2: last slot of 16
    '{1'b0, 24'd1024, 32'h1000, 16'd10,     16'd3,      16'd15,     32'h13C0, 16'd7, 16'd9,  1'b0, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic configure(input logic half, input logic [SIZE_W-1:0] sz,
                           input logic [ADDR_W-1:0] base);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_half = half; cfg_size = sz; cfg_base = base;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_base = '0; cfg_size = '0; cfg_half = 1'b0;
    wr_we = 1'b0; wr_val = '0; rd_we = 1'b0; rd_val = '0; slot_idx = 16'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    check("R10", "addr",  64'(slot_addr), 64'h0);
    check("R10", "used",  64'(used), 64'h0);
    check("R10", "left",  64'(left), 64'h0);
    check("R10", "full",  64'(full), 64'h1);
    check("R10", "empty", 64'(empty), 64'h1);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      configure(VEC[i].half, VEC[i].size, VEC[i].base);
      wr_we = 1'b1; wr_val = VEC[i].wr; rd_we = 1'b1; rd_val = VEC[i].rd;
      @(negedge clk);
      wr_we = 1'b0; rd_we = 1'b0; slot_idx = VEC[i].idx;
      #1;
      check("R2/R3", "addr", 64'(slot_addr), 64'(VEC[i].e_addr));
      check("R4",    "used", 64'(used), 64'(VEC[i].e_used));
      check("R5",    "left", 64'(left), 64'(VEC[i].e_left));
      check("R6",    "full", 64'(full), 64'(VEC[i].e_full));
      check("R6",    "empty", 64'(empty), 64'(VEC[i].e_empty));
    end

    // R9: translate answer changes with no clock edge (16 slots, base 0x1000)
    @(negedge clk);
    #1 slot_idx = 16'd17;
    #1 check("R9", "addr comb", 64'(slot_addr), 64'h1040);
    slot_idx = 16'd34;
    #1 check("R9", "addr comb", 64'(slot_addr), 64'h1080);

    // R7: reconfigure clears indices (previous used was 7)
    configure(1'b0, 24'd2048, 32'h4000);
    #1;
    check("R7", "used after cfg", 64'(used), 64'h0);
    check("R7", "left after cfg", 64'(left), 64'd32);
    check("R7", "empty after cfg", 64'(empty), 64'h1);
    slot_idx = 16'd33;
    #1 check("R7", "new base/count", 64'(slot_addr), 64'h4040);

    // R8: write port only touches write index
    @(negedge clk);
    wr_we = 1'b1; wr_val = 16'd9;
    @(negedge clk);
    wr_we = 1'b0;
    #1 check("R8", "used after wr only", 64'(used), 64'd9);
    rd_we = 1'b1; rd_val = 16'd4;
    @(negedge clk);
    rd_we = 1'b0;
    #1 check("R8", "used after rd only", 64'(used), 64'd5);

    // R8: configure beats index write in the same cycle
    @(negedge clk);
    cfg_valid = 1'b1; cfg_half = 1'b0; cfg_size = 24'd2048; cfg_base = 32'h4000;
    wr_we = 1'b1; wr_val = 16'd12;
    @(negedge clk);
    cfg_valid = 1'b0; wr_we = 1'b0;
    #1 check("R8", "cfg priority used", 64'(used), 64'h0);
    check("R8", "cfg priority empty", 64'(empty), 64'h1);

    done = 1'b1;
    finish_run();
  end
endmodule